// File: doc/BRIEF.md
# Multi-width banked register file

This block stores the sixteen 16-bit general-purpose registers of a processor datapath. It returns and accepts operands at four widths over the same storage. A byte access sees one half of one of the low eight registers. A word access sees one register. A pair access sees two adjacent registers as a 32-bit value, and a quad access sees four adjacent registers as a 64-bit value. Two combinational read ports and one clocked write port each carry a size code and a register specifier.

Register 15 is the stack pointer, and the block keeps two copies of it. A mode input selects which copy appears at position 15, so the system stack and the normal stack never disturb each other. Register 14 holds the stack segment, so reading pair 14 gives a full stack address for the current mode. Misaligned pair and quad specifiers are flagged and have no effect.

Top module: `regfile_mw`

## Requirements
- R1: After reset every register, including both stack copies, reads as zero.
- R2: Size code 1 (word) uses spec as the register number. A read returns the register in data[15:0] with all higher bits zero, and a write replaces the whole register.
- R3: Size code 0 (byte) uses spec[2:0] as the register number (0 to 7). spec[3]=0 selects the high byte and spec[3]=1 the low byte. A read returns the byte in data[7:0] with all higher bits zero. A write takes data[7:0] and leaves the other byte of the register unchanged.
- R4: Size code 2 (pair) with an even spec n maps register n to data[31:16] and register n+1 to data[15:0], with bits above 31 zero, for both read and write.
- R5: Size code 3 (quad) with spec n a multiple of 4 maps register n to data[63:48], n+1 to data[47:32], n+2 to data[31:16] and n+3 to data[15:0].
- R6: An odd pair spec, or a quad spec that is not a multiple of 4, is illegal. A read port then raises its illegal flag and returns zero data. The write port raises wr_illegal_o while wr_en_i is high and writes nothing.
- R7: Position 15 is banked by mode. With sys_mode_i=1 every access sees the system stack register, and with sys_mode_i=0 it sees the normal one. A write through one mode never changes the copy belonging to the other mode.
- R8: A pair read at spec 14 returns register 14 in data[31:16] and the current mode's stack register in data[15:0].
- R9: A read in the same cycle as a write to an overlapping register returns the old contents. The new value is visible from the cycle after the clock edge.
- R10: The two read ports are independent, and each may use any size and spec in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_mode_i | input | 1 | 1 selects the system stack copy, 0 selects the normal one |
| rd_a_size_i | input | 2 | Read port A size code |
| rd_a_spec_i | input | 4 | Read port A register specifier |
| rd_a_data_o | output | 64 | Read port A data, right aligned |
| rd_a_illegal_o | output | 1 | Read port A misaligned specifier |
| rd_b_size_i | input | 2 | Read port B size code |
| rd_b_spec_i | input | 4 | Read port B register specifier |
| rd_b_data_o | output | 64 | Read port B data, right aligned |
| rd_b_illegal_o | output | 1 | Read port B misaligned specifier |
| wr_en_i | input | 1 | Write strobe |
| wr_size_i | input | 2 | Write size code |
| wr_spec_i | input | 4 | Write register specifier |
| wr_data_i | input | 64 | Write data, right aligned |
| wr_illegal_o | output | 1 | Write rejected for misalignment |

## Verification
On every cycle the assertions check the misalignment flags on all three ports and that an illegal read returns zero. They check the zero upper bits of byte, word and pair reads, and they check that without a write the read data holds steady while the port selection and mode stay the same. Only the bench scenarios can show what the data values are. Those values come from the sub-register placement at each width, from writes at one width read back at another, from the separation of the two stack copies, and from reads that return old data during a write.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_PAIR = 2'd2,
    SZ_QUAD = 2'd3
  } size_e;
endpackage

// File: rtl/rf_read_view.sv
module rf_read_view #(
  parameter int WORD_W   = 16,
  parameter int NUM_REGS = 16,
  localparam int SPEC_W  = $clog2(NUM_REGS),
  localparam int DATA_W  = 4 * WORD_W,
  localparam int HALF_W  = WORD_W / 2
) (
  input  logic [WORD_W-1:0] regs_i [NUM_REGS],
  input  logic [1:0]        size_i,
  input  logic [SPEC_W-1:0] spec_i,
  output logic [DATA_W-1:0] data_o,
  output logic              illegal_o
);
  import rf_pkg::*;

  logic [WORD_W-1:0] byte_src;

  always_comb begin
    data_o    = '0;
    illegal_o = 1'b0;
    byte_src  = regs_i[{1'b0, spec_i[SPEC_W-2:0]}];
    case (size_e'(size_i))
      SZ_BYTE: data_o[HALF_W-1:0] = spec_i[SPEC_W-1] ? byte_src[HALF_W-1:0]
                                                     : byte_src[WORD_W-1:HALF_W];
      SZ_WORD: data_o[WORD_W-1:0] = regs_i[spec_i];
      SZ_PAIR: begin
        if (spec_i[0]) illegal_o = 1'b1;
        else data_o[2*WORD_W-1:0] = {regs_i[spec_i], regs_i[{spec_i[SPEC_W-1:1], 1'b1}]};
      end
      default: begin
        if (spec_i[1:0] != 2'b00) illegal_o = 1'b1;
        else data_o = {regs_i[{spec_i[SPEC_W-1:2], 2'd0}], regs_i[{spec_i[SPEC_W-1:2], 2'd1}],
                       regs_i[{spec_i[SPEC_W-1:2], 2'd2}], regs_i[{spec_i[SPEC_W-1:2], 2'd3}]};
      end
    endcase
  end
endmodule

// File: rtl/rf_write_ctrl.sv
module rf_write_ctrl #(
  parameter int WORD_W   = 16,
  parameter int NUM_REGS = 16,
  localparam int SPEC_W  = $clog2(NUM_REGS),
  localparam int DATA_W  = 4 * WORD_W,
  localparam int HALF_W  = WORD_W / 2
) (
  input  logic                en_i,
  input  logic [1:0]          size_i,
  input  logic [SPEC_W-1:0]   spec_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [NUM_REGS-1:0] we_hi_o,
  output logic [NUM_REGS-1:0] we_lo_o,
  output logic [WORD_W-1:0]   wval_o [NUM_REGS],
  output logic                illegal_o
);
  import rf_pkg::*;

  logic                bad;
  logic [SPEC_W-1:0]   idx;
  logic [NUM_REGS-1:0] hi_sel, lo_sel;

  always_comb begin
    bad    = 1'b0;
    hi_sel = '0;
    lo_sel = '0;
    idx    = '0;
    for (int i = 0; i < NUM_REGS; i++) wval_o[i] = '0;
    case (size_e'(size_i))
      SZ_BYTE: begin
        idx = {1'b0, spec_i[SPEC_W-2:0]};
        // byte replicated into both halves; enables pick the half
        wval_o[idx] = {data_i[HALF_W-1:0], data_i[HALF_W-1:0]};
        if (spec_i[SPEC_W-1]) lo_sel[idx] = 1'b1;
        else                  hi_sel[idx] = 1'b1;
      end
      SZ_WORD: begin
        wval_o[spec_i] = data_i[WORD_W-1:0];
        hi_sel[spec_i] = 1'b1;
        lo_sel[spec_i] = 1'b1;
      end
      SZ_PAIR: begin
        bad = spec_i[0];
        for (int k = 0; k < 2; k++) begin
          idx = {spec_i[SPEC_W-1:1], 1'(k)};
          wval_o[idx] = data_i[(1-k)*WORD_W +: WORD_W];
          hi_sel[idx] = 1'b1;
          lo_sel[idx] = 1'b1;
        end
      end
      default: begin
        bad = (spec_i[1:0] != 2'b00);
        for (int k = 0; k < 4; k++) begin
          idx = {spec_i[SPEC_W-1:2], 2'(k)};
          wval_o[idx] = data_i[(3-k)*WORD_W +: WORD_W];
          hi_sel[idx] = 1'b1;
          lo_sel[idx] = 1'b1;
        end
      end
    endcase
    illegal_o = en_i & bad;
    we_hi_o   = (en_i && !bad) ? hi_sel : '0;
    we_lo_o   = (en_i && !bad) ? lo_sel : '0;
  end
endmodule

// File: rtl/regfile_mw.sv
module regfile_mw #(
  parameter int WORD_W   = 16,
  parameter int NUM_REGS = 16,
  localparam int SPEC_W  = $clog2(NUM_REGS),
  localparam int DATA_W  = 4 * WORD_W,
  localparam int HALF_W  = WORD_W / 2,
  localparam int SP_IDX  = NUM_REGS - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_mode_i,
  input  logic [1:0]        rd_a_size_i,
  input  logic [SPEC_W-1:0] rd_a_spec_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  output logic              rd_a_illegal_o,
  input  logic [1:0]        rd_b_size_i,
  input  logic [SPEC_W-1:0] rd_b_spec_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  output logic              rd_b_illegal_o,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_size_i,
  input  logic [SPEC_W-1:0] wr_spec_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_illegal_o
);
  logic [WORD_W-1:0]   gpr [SP_IDX];
  logic [WORD_W-1:0]   sp_sys, sp_usr;
  logic [WORD_W-1:0]   view [NUM_REGS];
  logic [NUM_REGS-1:0] we_hi, we_lo;
  logic [WORD_W-1:0]   wval [NUM_REGS];

  logic [1:0]        rp_size [2];
  logic [SPEC_W-1:0] rp_spec [2];
  logic [DATA_W-1:0] rp_data [2];
  logic              rp_ill  [2];

  for (genvar i = 0; i < SP_IDX; i++) begin : g_view
    assign view[i] = gpr[i];
  end
  assign view[SP_IDX] = sys_mode_i ? sp_sys : sp_usr;

  assign rp_size[0] = rd_a_size_i;
  assign rp_spec[0] = rd_a_spec_i;
  assign rp_size[1] = rd_b_size_i;
  assign rp_spec[1] = rd_b_spec_i;

  for (genvar p = 0; p < 2; p++) begin : g_rd
    rf_read_view #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS)) u_rd (
      .regs_i   (view),
      .size_i   (rp_size[p]),
      .spec_i   (rp_spec[p]),
      .data_o   (rp_data[p]),
      .illegal_o(rp_ill[p])
    );
  end

  assign rd_a_data_o    = rp_data[0];
  assign rd_a_illegal_o = rp_ill[0];
  assign rd_b_data_o    = rp_data[1];
  assign rd_b_illegal_o = rp_ill[1];

  rf_write_ctrl #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS)) u_wr (
    .en_i     (wr_en_i),
    .size_i   (wr_size_i),
    .spec_i   (wr_spec_i),
    .data_i   (wr_data_i),
    .we_hi_o  (we_hi),
    .we_lo_o  (we_lo),
    .wval_o   (wval),
    .illegal_o(wr_illegal_o)
  );

  for (genvar i = 0; i < SP_IDX; i++) begin : g_gpr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gpr[i] <= '0;
      end else begin
        if (we_hi[i]) gpr[i][WORD_W-1:HALF_W] <= wval[i][WORD_W-1:HALF_W];
        if (we_lo[i]) gpr[i][HALF_W-1:0]      <= wval[i][HALF_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_sys <= '0;
      sp_usr <= '0;
    end else if (sys_mode_i) begin
      if (we_hi[SP_IDX]) sp_sys[WORD_W-1:HALF_W] <= wval[SP_IDX][WORD_W-1:HALF_W];
      if (we_lo[SP_IDX]) sp_sys[HALF_W-1:0]      <= wval[SP_IDX][HALF_W-1:0];
    end else begin
      if (we_hi[SP_IDX]) sp_usr[WORD_W-1:HALF_W] <= wval[SP_IDX][WORD_W-1:HALF_W];
      if (we_lo[SP_IDX]) sp_usr[HALF_W-1:0]      <= wval[SP_IDX][HALF_W-1:0];
    end
  end
endmodule

// File: rtl/rf_chk.sv
module rf_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sys_mode_i,
  input logic [1:0]  rd_a_size_i,
  input logic [3:0]  rd_a_spec_i,
  input logic [63:0] rd_a_data_o,
  input logic        rd_a_illegal_o,
  input logic [1:0]  rd_b_size_i,
  input logic [3:0]  rd_b_spec_i,
  input logic [63:0] rd_b_data_o,
  input logic        rd_b_illegal_o,
  input logic        wr_en_i,
  input logic [1:0]  wr_size_i,
  input logic [3:0]  wr_spec_i,
  input logic        wr_illegal_o
);
  AST_A_MISALIGN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_a_size_i == 2'd2 && rd_a_spec_i[0]) || (rd_a_size_i == 2'd3 && rd_a_spec_i[1:0] != 2'b00))
    == rd_a_illegal_o); // R6
  AST_B_MISALIGN_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_b_size_i == 2'd2 && rd_b_spec_i[0]) || (rd_b_size_i == 2'd3 && rd_b_spec_i[1:0] != 2'b00))
    == rd_b_illegal_o); // R6
  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_illegal_o |-> rd_a_data_o == '0) and (rd_b_illegal_o |-> rd_b_data_o == '0)); // R6
  AST_WR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_illegal_o == (wr_en_i && ((wr_size_i == 2'd2 && wr_spec_i[0]) ||
                                 (wr_size_i == 2'd3 && wr_spec_i[1:0] != 2'b00)))); // R6
  AST_BYTE_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_size_i == 2'd0 |-> rd_a_data_o[63:8] == '0); // R3
  AST_WORD_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_b_size_i == 2'd1 |-> rd_b_data_o[63:16] == '0); // R2
  AST_PAIR_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_size_i == 2'd2 |-> rd_a_data_o[63:32] == '0); // R4
  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (($stable(rd_a_size_i) && $stable(rd_a_spec_i) && $stable(sys_mode_i))
                  -> $stable(rd_a_data_o))); // R9
endmodule

bind regfile_mw rf_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sys_mode_i(sys_mode_i),
  .rd_a_size_i(rd_a_size_i), .rd_a_spec_i(rd_a_spec_i),
  .rd_a_data_o(rd_a_data_o), .rd_a_illegal_o(rd_a_illegal_o),
  .rd_b_size_i(rd_b_size_i), .rd_b_spec_i(rd_b_spec_i),
  .rd_b_data_o(rd_b_data_o), .rd_b_illegal_o(rd_b_illegal_o),
  .wr_en_i(wr_en_i), .wr_size_i(wr_size_i), .wr_spec_i(wr_spec_i),
  .wr_illegal_o(wr_illegal_o)
);

// File: tb/sim_regfile_mw.sv
`timescale 1ns/1ps
module sim_regfile_mw;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic [1:0]  a_sz = '0, b_sz = '0, w_sz = '0;
  logic [3:0]  a_sp = '0, b_sp = '0, w_sp = '0;
  logic        w_en = 1'b0;
  logic [63:0] w_d = '0;
  logic [63:0] a_d, b_d;
  logic        a_ill, b_ill, w_ill;

  int checks = 0, fails = 0;
  logic [15:0] m_r [16];
  logic [15:0] m_sys, m_usr;

  always #2 clk = ~clk;

  regfile_mw u0 (
    .clk_i(clk), .rst_ni(rst_n), .sys_mode_i(mode),
    .rd_a_size_i(a_sz), .rd_a_spec_i(a_sp), .rd_a_data_o(a_d), .rd_a_illegal_o(a_ill),
    .rd_b_size_i(b_sz), .rd_b_spec_i(b_sp), .rd_b_data_o(b_d), .rd_b_illegal_o(b_ill),
    .wr_en_i(w_en), .wr_size_i(w_sz), .wr_spec_i(w_sp), .wr_data_i(w_d),
    .wr_illegal_o(w_ill)
  );

  function automatic logic [15:0] mget(int i, bit m);
    if (i == 15) return m ? m_sys : m_usr;
    return m_r[i];
  endfunction

  function automatic bit mbad(logic [1:0] sz, logic [3:0] sp);
    return (sz == 2'd2 && sp % 2 != 0) || (sz == 2'd3 && sp % 4 != 0);
  endfunction

  function automatic logic [63:0] mread(logic [1:0] sz, logic [3:0] sp, bit m);
    logic [15:0] w;
    if (mbad(sz, sp)) return 64'd0;
    case (sz)
      2'd0: begin w = mget(sp % 8, m); return sp >= 8 ? 64'(w[7:0]) : 64'(w[15:8]); end
      2'd1: return 64'(mget(sp, m));
      2'd2: return {32'd0, mget(sp, m), mget(sp + 1, m)};
      default: return {mget(sp, m), mget(sp + 1, m), mget(sp + 2, m), mget(sp + 3, m)};
    endcase
  endfunction

  function automatic void mput(int i, bit m, logic [15:0] v);
    if (i == 15) begin if (m) m_sys = v; else m_usr = v; end
    else m_r[i] = v;
  endfunction

  function automatic void mwrite(logic [1:0] sz, logic [3:0] sp, bit m, logic [63:0] d);
    logic [15:0] w;
    if (mbad(sz, sp)) return;
    case (sz)
      2'd0: begin
        w = mget(sp % 8, m);
        if (sp >= 8) w[7:0] = d[7:0]; else w[15:8] = d[7:0];
        mput(sp % 8, m, w);
      end
      2'd1: mput(sp, m, d[15:0]);
      2'd2: begin mput(sp, m, d[31:16]); mput(sp + 1, m, d[15:0]); end
      default: for (int k = 0; k < 4; k++) mput(sp + k, m, d[(3-k)*16 +: 16]);
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive after negedge, compare before next posedge, then advance model
  task automatic step(string tag, bit m, logic [1:0] asz, logic [3:0] asp,
                      logic [1:0] bsz, logic [3:0] bsp,
                      bit we, logic [1:0] wsz, logic [3:0] wsp, logic [63:0] wd);
    @(negedge clk);
    mode = m; a_sz = asz; a_sp = asp; b_sz = bsz; b_sp = bsp;
    w_en = we; w_sz = wsz; w_sp = wsp; w_d = wd;
    #1;
    chk(tag, "port A", {a_ill, a_d}, {mbad(asz, asp), mread(asz, asp, m)});
    chk(tag, "port B", {b_ill, b_d}, {mbad(bsz, bsp), mread(bsz, bsp, m)});
    chk(tag, "write flag", {64'd0, w_ill}, {64'd0, we && mbad(wsz, wsp)});
    @(posedge clk);
    if (we) mwrite(wsz, wsp, m, wd);
  endtask

  task automatic rd(string tag, bit m, logic [1:0] sz, logic [3:0] sp);
    step(tag, m, sz, sp, 2'd1, 4'd0, 1'b0, 2'd0, 4'd0, 64'd0);
  endtask

  task automatic wr(string tag, bit m, logic [1:0] sz, logic [3:0] sp, logic [63:0] d);
    step(tag, m, sz, sp, sz, sp, 1'b1, sz, sp, d);
  endtask

  initial begin
    #400_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_r[i] = '0;
    m_sys = '0; m_usr = '0;
    #9 rst_n = 1'b1;

    // R1: reset state, both stack copies
    for (int i = 0; i < 16; i++) rd("R1", 1'b1, 2'd1, 4'(i));
    rd("R1", 1'b0, 2'd1, 4'd15);
    rd("R1", 1'b0, 2'd3, 4'd12);

    // R2: word writes, readback
    for (int i = 0; i < 15; i++) wr("R2", 1'b0, 2'd1, 4'(i), {48'hffff_ffff_ffff, 16'h1100 + 16'(i * 16'h0111)});
    for (int i = 0; i < 15; i++) rd("R2", 1'b0, 2'd1, 4'(i));

    // R3: byte halves, other half kept
    wr("R3", 1'b0, 2'd0, 4'd3, 64'hdead_beef_cafe_00a5);
    rd("R3", 1'b0, 2'd1, 4'd3);
    wr("R3", 1'b0, 2'd0, 4'd11, 64'h0000_0000_0000_ff3c);
    rd("R3", 1'b0, 2'd1, 4'd3);
    rd("R3", 1'b0, 2'd0, 4'd3);
    rd("R3", 1'b0, 2'd0, 4'd11);
    for (int i = 0; i < 16; i++) rd("R3", 1'b1, 2'd0, 4'(i));

    // R4: pairs
    wr("R4", 1'b0, 2'd2, 4'd6, 64'h0000_0000_1234_5678);
    rd("R4", 1'b0, 2'd1, 4'd6);
    rd("R4", 1'b0, 2'd1, 4'd7);
    for (int i = 0; i < 16; i += 2) rd("R4", 1'b0, 2'd2, 4'(i));

    // R5: quads
    wr("R5", 1'b0, 2'd3, 4'd4, 64'ha1a2_b3b4_c5c6_d7d8);
    for (int i = 4; i < 8; i++) rd("R5", 1'b0, 2'd1, 4'(i));
    for (int i = 0; i < 16; i += 4) rd("R5", 1'b1, 2'd3, 4'(i));

    // R6: misaligned, no write
    wr("R6", 1'b0, 2'd2, 4'd5, 64'h0000_0000_eeee_eeee);
    wr("R6", 1'b0, 2'd3, 4'd6, 64'hffff_ffff_ffff_ffff);
    rd("R6", 1'b0, 2'd3, 4'd4);
    rd("R6", 1'b0, 2'd3, 4'd8);
    rd("R6", 1'b0, 2'd2, 4'd9);

    // R7: banked stack register
    wr("R7", 1'b1, 2'd1, 4'd15, 64'h0000_0000_0000_5a5a);
    wr("R7", 1'b0, 2'd1, 4'd15, 64'h0000_0000_0000_c3c3);
    rd("R7", 1'b1, 2'd1, 4'd15);
    rd("R7", 1'b0, 2'd1, 4'd15);
    wr("R7", 1'b1, 2'd3, 4'd12, 64'h1111_2222_3333_4444);
    rd("R7", 1'b0, 2'd3, 4'd12);
    rd("R7", 1'b1, 2'd3, 4'd12);

    // R8: stack address pair in each mode
    wr("R8", 1'b0, 2'd2, 4'd14, 64'h0000_0000_00aa_7777);
    rd("R8", 1'b0, 2'd2, 4'd14);
    rd("R8", 1'b1, 2'd2, 4'd14);

    // R9: read during overlapping write sees old data
    step("R9", 1'b0, 2'd2, 4'd6, 2'd0, 4'd6, 1'b1, 2'd3, 4'd4, 64'h9999_8888_7777_6666);
    rd("R9", 1'b0, 2'd2, 4'd6);
    step("R9", 1'b1, 2'd1, 4'd15, 2'd2, 4'd14, 1'b1, 2'd1, 4'd15, 64'h0000_0000_0000_0bad);
    rd("R9", 1'b1, 2'd2, 4'd14);

    // R10: mixed random traffic on both ports
    for (int n = 0; n < 600; n++)
      step("R10", 1'($urandom), 2'($urandom), 4'($urandom), 2'($urandom), 4'($urandom),
           1'($urandom), 2'($urandom), 4'($urandom), {$urandom, $urandom});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule